// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic/Logic Slice

This block is a purely combinational arithmetic/logic slice. It takes two operand words, a carry input and a three-bit function code. It returns a result word, a carry output and a signed-overflow flag. Eight functions are available: two constants (all zeros and all ones), three arithmetic functions (sum, first-minus-second, second-minus-first) and three bitwise functions (exclusive-or, inclusive-or, and).

Subtraction works by adding the inverted subtrahend. The caller holds the carry input high, which adds the final one and completes the two's complement. The carry output of one slice can feed the carry input of the next slice. Two slices chained this way with the same function code act as an eight-bit unit, and longer chains work the same way. The operand width is a parameter. Its default is four bits.

Top module: `alu4_slice`

## Requirements
- R1: Function code 3'b000 drives the result to all zeros. For this code, carry output and overflow are 0 whatever the operands and carry input are.
- R2: Function code 3'b111 drives the result to all ones. For this code, carry output and overflow are 0 whatever the operands and carry input are.
- R3: Function code 3'b011 gives {carry output, result} equal to the unsigned sum opa + opb + cin.
- R4: Function code 3'b010 gives {carry output, result} equal to opa + (~opb) + cin. With cin = 1 the result is opa − opb modulo 2^W, and the carry output is 1 exactly when opa ≥ opb (unsigned).
- R5: Function code 3'b001 gives {carry output, result} equal to (~opa) + opb + cin. With cin = 1 the result is opb − opa modulo 2^W, and the carry output is 1 exactly when opb ≥ opa (unsigned).
- R6: Function codes 3'b100, 3'b101 and 3'b110 give the bitwise XOR, OR and AND of opa and opb. Carry output and overflow are 0, and the carry input has no effect on any output.
- R7: For the three arithmetic codes, overflow is 1 exactly when the two's-complement sum of the two operands presented to the adder, plus cin, falls outside the range −2^(W−1) to 2^(W−1)−1. The operands presented to the adder are opa and opb, with the subtrahend inverted for the subtract codes.
- R8: Two slices with a shared function code, where the low slice's carry output drives the high slice's carry input, produce the eight-bit result, carry and overflow of the same function applied to the concatenated operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (4) | First operand |
| opb | input | W (4) | Second operand |
| cin | input | 1 | Carry input; hold at 1 for subtraction |
| fsel | input | 3 | Function code |
| fout | output | W (4) | Result word |
| cout | output | 1 | Carry out of the most significant bit, arithmetic codes only |
| ovf | output | 1 | Two's-complement overflow, arithmetic codes only |

## Verification
The assertions check the slice only while every input is a known 0 or 1. Combinations that contain X or Z are skipped, so the checks never fire on the undriven inputs that exist before the first stimulus. The bench drives fully defined values on every input at every step. It changes them half a clock period before it samples, so the combinational outputs have settled when they are read. The single-slice sweep covers every operand pair, every carry input and every function code. The chained sweep steps across the eight-bit operand space for each function.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    FN_ZERO  = 3'b000,
    FN_BSUBA = 3'b001,
    FN_ASUBB = 3'b010,
    FN_ADD   = 3'b011,
    FN_XOR   = 3'b100,
    FN_OR    = 3'b101,
    FN_AND   = 3'b110,
    FN_ONES  = 3'b111
  } fn_e;

  function automatic logic fn_is_arith(input fn_e f);
    return (f == FN_BSUBA) || (f == FN_ASUBB) || (f == FN_ADD);
  endfunction

  function automatic logic fn_is_bitwise(input fn_e f);
    return (f == FN_XOR) || (f == FN_OR) || (f == FN_AND);
  endfunction
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int W = 4
) (
  input  alu4_pkg::fn_e fsel,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic [W-1:0]  xa,
  output logic [W-1:0]  xb
);
  timeunit 1ns;
  timeprecision 1ps;
  import alu4_pkg::*;

  // Invert the subtrahend so that the adder plus cin=1 forms its two's complement.
  logic inv_a, inv_b;
  assign inv_a = (fsel == FN_BSUBA);
  assign inv_b = (fsel == FN_ASUBB);

  assign xa = inv_a ? ~opa : opa;
  assign xb = inv_b ? ~opb : opb;

  always_comb begin
    if (!$isunknown({fsel, opa, opb})) begin
      p_one_inversion_r4: assert (!(inv_a && inv_b))
        else $error("both operands inverted");
      p_xor_inverted_r5: assert (!inv_a || ((xa ^ opa) == {W{1'b1}}))
        else $error("first operand not inverted for B-A");
    end
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] xa,
  input  logic [W-1:0] xb,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_msb_in,
  output logic         c_msb_out
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p_bit, g_bit_w;
    assign p_bit    = xa[i] ^ xb[i];
    assign g_bit_w  = xa[i] & xb[i];
    assign sum[i]   = p_bit ^ carry[i];
    assign carry[i+1] = g_bit_w | (p_bit & carry[i]);
  end

  assign c_msb_in  = carry[W-1];
  assign c_msb_out = carry[W];

  function automatic logic [W:0] wide_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic ci);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  always_comb begin
    if (!$isunknown({xa, xb, cin})) begin
      p_chain_sum_r3: assert ({c_msb_out, sum} == wide_sum(xa, xb, cin))
        else $error("ripple chain disagrees with wide sum");
    end
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 4
) (
  input  alu4_pkg::fn_e fsel,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic [W-1:0]  lres
);
  timeunit 1ns;
  timeprecision 1ps;
  import alu4_pkg::*;

  always_comb begin
    unique case (fsel)
      FN_XOR:  lres = opa ^ opb;
      FN_OR:   lres = opa | opb;
      FN_AND:  lres = opa & opb;
      default: lres = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({fsel, opa, opb}) && (fsel == FN_AND)) begin
      p_and_within_or_r6: assert ((lres & ~(opa | opb)) == '0)
        else $error("AND result has bits outside OR");
    end
  end
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [2:0]   fsel,
  output logic [W-1:0] fout,
  output logic         cout,
  output logic         ovf
);
  timeunit 1ns;
  timeprecision 1ps;
  import alu4_pkg::*;

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  fn_e         fn;
  logic [W-1:0] xa, xb, sum, lres;
  logic         c_msb_in, c_msb_out, arith_en;

  assign fn = fn_e'(fsel);

  alu_operand_cond #(.W(W)) u_cond (
    .fsel(fn), .opa(opa), .opb(opb), .xa(xa), .xb(xb)
  );

  alu_ripple #(.W(W)) u_add (
    .xa(xa), .xb(xb), .cin(cin), .sum(sum),
    .c_msb_in(c_msb_in), .c_msb_out(c_msb_out)
  );

  alu_bitwise #(.W(W)) u_logic (
    .fsel(fn), .opa(opa), .opb(opb), .lres(lres)
  );

  assign arith_en = fn_is_arith(fn);

  always_comb begin
    if (arith_en)               fout = sum;
    else if (fn_is_bitwise(fn)) fout = lres;
    else if (fn == FN_ONES)     fout = ALL_ONES;
    else                        fout = '0;
  end

  assign cout = arith_en & c_msb_out;
  assign ovf  = arith_en & (c_msb_in ^ c_msb_out);

  // Signed overflow restated through a sign-extended sum.
  function automatic logic sext_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                    input logic ci);
    logic [W:0] s;
    s = {x[W-1], x} + {y[W-1], y} + {{W{1'b0}}, ci};
    return s[W] ^ s[W-1];
  endfunction

  always_comb begin
    if (!$isunknown({opa, opb, cin, fsel})) begin
      p_clear_r1: assert (fn != FN_ZERO || (fout == '0 && !cout && !ovf))
        else $error("clear code output wrong");
      p_preset_r2: assert (fn != FN_ONES || (fout == ALL_ONES && !cout && !ovf))
        else $error("preset code output wrong");
      p_add_r3: assert (fn != FN_ADD ||
                        {cout, fout} == ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin}))
        else $error("sum wrong");
      p_asubb_r4: assert (!(fn == FN_ASUBB && cin) ||
                          (fout == W'(opa - opb) && cout == (opa >= opb)))
        else $error("A-B wrong");
      p_bsuba_r5: assert (!(fn == FN_BSUBA && cin) ||
                          (fout == W'(opb - opa) && cout == (opb >= opa)))
        else $error("B-A wrong");
      p_bitwise_r6: assert (!fn_is_bitwise(fn) || (!cout && !ovf))
        else $error("flags set on bitwise code");
      p_ovf_r7: assert (!arith_en || ovf == sext_ovf(xa, xb, cin))
        else $error("overflow flag wrong");
    end
  end
endmodule

// File: tb/tb_alu4_slice.sv
module tb_alu4_slice;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [3:0] a, b, fo;
  logic       ci, co, ov;
  logic [2:0] fs;

  alu4_slice #(.W(4)) dut (
    .opa(a), .opb(b), .cin(ci), .fsel(fs), .fout(fo), .cout(co), .ovf(ov)
  );

  // Two chained slices form an 8-bit unit (R8).
  logic [7:0] wa, wb, wf;
  logic       wci, mid_c, wco, lo_ov, wov;
  alu4_slice #(.W(4)) dut_lo (
    .opa(wa[3:0]), .opb(wb[3:0]), .cin(wci), .fsel(fs),
    .fout(wf[3:0]), .cout(mid_c), .ovf(lo_ov)
  );
  alu4_slice #(.W(4)) dut_hi (
    .opa(wa[7:4]), .opb(wb[7:4]), .cin(mid_c), .fsel(fs),
    .fout(wf[7:4]), .cout(wco), .ovf(wov)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic string req_of(input int f);
    case (f)
      0: return "R1";
      7: return "R2";
      3: return "R3";
      2: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Expected {result, carry, overflow} computed arithmetically for width nb.
  function automatic void model(input int nb, input int f, input int x, input int y,
                                input int c, output int r, output int rc, output int rv);
    int m, ux, uy, tot, sx, sy, st;
    m = 1 << nb;
    rc = 0; rv = 0;
    case (f)
      0: r = 0;
      7: r = m - 1;
      4: r = x ^ y;
      5: r = x | y;
      6: r = x & y;
      default: begin
        ux = (f == 1) ? (m - 1 - x) : x;
        uy = (f == 2) ? (m - 1 - y) : y;
        tot = ux + uy + c;
        r  = tot % m;
        rc = (tot >= m) ? 1 : 0;
        sx = (ux >= m/2) ? ux - m : ux;
        sy = (uy >= m/2) ? uy - m : uy;
        st = sx + sy + c;
        rv = (st > m/2 - 1 || st < -(m/2)) ? 1 : 0;
      end
    endcase
  endfunction

  task automatic check(input string req, input int got_r, input int got_c, input int got_v,
                       input int er, input int ec, input int ev, input string ctx);
    n_cmp++;
    if (got_r != er || got_c != ec || got_v != ev) begin
      n_bad++;
      $display("FAIL %s %s: got r=%0d c=%0d v=%0d expected r=%0d c=%0d v=%0d",
               req, ctx, got_r, got_c, got_v, er, ec, ev);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int er, ec, ev;
    a = '0; b = '0; ci = 1'b0; fs = 3'b000;
    wa = '0; wb = '0; wci = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Quiet state with all inputs zero: clear code (R1).
    check("R1", fo, co, ov, 0, 0, 0, "idle");

    // Exhaustive single-slice sweep: R1..R7 (R7 via overflow column).
    for (int f = 0; f < 8; f++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            fs = 3'(f); a = 4'(x); b = 4'(y); ci = c[0];
            @(negedge clk);
            model(4, f, x, y, c, er, ec, ev);
            check((f >= 1 && f <= 3 && ev != int'(ov)) ? "R7" : req_of(f),
                  fo, co, ov, er, ec, ev,
                  $sformatf("f=%0d a=%0d b=%0d ci=%0d", f, x, y, c));
          end

    // Directed boundaries: max positive + 1 overflows (R7), A-B with A<B borrows (R4).
    @(posedge clk); fs = 3'b011; a = 4'd7; b = 4'd1; ci = 1'b0;
    @(negedge clk); check("R7", fo, co, ov, 8, 0, 1, "7+1");
    @(posedge clk); fs = 3'b010; a = 4'd3; b = 4'd5; ci = 1'b1;
    @(negedge clk); check("R4", fo, co, ov, 14, 0, 0, "3-5");
    @(posedge clk); fs = 3'b001; a = 4'd3; b = 4'd5; ci = 1'b1;
    @(negedge clk); check("R5", fo, co, ov, 2, 1, 0, "5-3");

    // Chained 8-bit sweep (R8).
    for (int f = 0; f < 8; f++)
      for (int x = 0; x < 256; x += 17)
        for (int y = 3; y < 256; y += 23)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            fs = 3'(f); wa = 8'(x); wb = 8'(y); wci = c[0];
            @(negedge clk);
            model(8, f, x, y, c, er, ec, ev);
            check("R8", wf, wco, wov, er, ec, ev,
                  $sformatf("wide f=%0d a=%0d b=%0d ci=%0d", f, x, y, c));
          end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule